// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises a doorbell interrupt between the two ports of a shared memory. Two reserved words at the top of the address space act as mailboxes: the highest word belongs to the right port and the word just below it belongs to the left port. When one port writes into the other port's mailbox, the owner's active-low interrupt output goes low. It stays low until the owner reads its own mailbox. The message itself sits in the ordinary memory; this block only watches the access strobes.

Each port supplies its address, chip select, write strobe, output enable and the busy flag from the collision arbiter. A port that is marked busy has lost arbitration for that cycle. Its write cannot ring the other side's doorbell, and its read cannot acknowledge its own. The block is fully synchronous. Every event is sampled on a rising clock edge, and the interrupt outputs come straight from registers, so they change one cycle after the access that caused the change.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge) both l_irq_n and r_irq_n are 1 (inactive).
- R2: A left access with l_cs=1, l_wr=1, l_busy=0 and l_addr equal to all ones drives r_irq_n to 0 after the next rising edge.
- R3: A right access with r_cs=1, r_wr=1, r_busy=0 and r_addr equal to all ones minus one drives l_irq_n to 0 after the next rising edge.
- R4: A right read (r_cs=1, r_wr=0, r_oe=1, r_busy=0) of address all ones returns r_irq_n to 1 after the next rising edge, unless a set of the same flag occurs in that cycle.
- R5: A left read (l_cs=1, l_wr=0, l_oe=1, l_busy=0) of address all ones minus one returns l_irq_n to 1 after the next rising edge, unless a set of the same flag occurs in that cycle.
- R6: A port reading the other port's mailbox leaves both interrupt outputs unchanged.
- R7: A write into the other port's mailbox made while the writer's busy input is 1 leaves the other port's interrupt unchanged.
- R8: A read of a port's own mailbox made while that port's busy input is 1 leaves its interrupt unchanged.
- R9: When a set and a clear of the same flag occur in one cycle, the flag ends up low (set has priority).
- R10: An access with chip select 0, a read with output enable 0, or a write to any address other than the other port's mailbox (including a port's own mailbox) changes neither interrupt.
- R11: With no qualifying set or clear event, each interrupt output holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | AW | Left port address |
| l_cs | input | 1 | Left chip select, active high |
| l_wr | input | 1 | Left direction: 1 write, 0 read |
| l_oe | input | 1 | Left output enable, active high |
| l_busy | input | 1 | Left lost arbitration this cycle, active high |
| r_addr | input | AW | Right port address |
| r_cs | input | 1 | Right chip select, active high |
| r_wr | input | 1 | Right direction: 1 write, 0 read |
| r_oe | input | 1 | Right output enable, active high |
| r_busy | input | 1 | Right lost arbitration this cycle, active high |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench targets several confusions that a faulty design could make. It swaps the two mailbox addresses, which would make a write to the wrong word ring the doorbell. It lets a read of the other port's mailbox acknowledge the interrupt, which would silently drop a pending message. It ignores the busy flag, which would let an arbitration loser ring or acknowledge the doorbell. It gives clear priority over set, which would lose a message that lands in the same cycle as the owner's acknowledge. It also clears on a read with output enable low, and it sets on a write with chip select low. Random traffic, weighted toward the two mailbox words, is compared cycle by cycle against a reference flag model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } mbx_side_e;

    localparam int unsigned NUM_SIDES = 2;

    // Per-port access strobes as seen by the doorbell logic.
    typedef struct packed {
        logic cs;
        logic wr;
        logic oe;
        logic busy;
    } mbx_ctrl_t;

    // Decoded doorbell events from one port.
    typedef struct packed {
        logic ring_peer;
        logic ack_own;
    } mbx_evt_t;

    // Mailbox word owned by a side: right owns the top word, left the one below.
    function automatic longint unsigned mbox_word(input mbx_side_e side, input int unsigned aw);
        longint unsigned top;
        top = (longint'(1) << aw) - 1;
        return (side == SIDE_R) ? top : top - 1;
    endfunction

    function automatic mbx_side_e peer_of(input mbx_side_e side);
        return (side == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned     AW       = 12,
    parameter logic [AW-1:0]   OWN_BOX  = '1,
    parameter logic [AW-1:0]   PEER_BOX = '1
) (
    input  logic [AW-1:0] addr_i,
    input  mbx_ctrl_t     ctrl_i,
    output mbx_evt_t      evt_o
);
    logic hit_own;
    logic hit_peer;
    logic granted;

    always_comb begin
        hit_own   = (addr_i == OWN_BOX);
        hit_peer  = (addr_i == PEER_BOX);
        granted   = ctrl_i.cs && !ctrl_i.busy;
        evt_o.ring_peer = granted && ctrl_i.wr && hit_peer;
        evt_o.ack_own   = granted && !ctrl_i.wr && ctrl_i.oe && hit_own;
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    always_ff @(posedge clk) begin
        if (rst)        irq_n_o <= 1'b1;
        else if (set_i) irq_n_o <= 1'b0;
        else if (clr_i) irq_n_o <= 1'b1;
    end

    // R9: set has priority over a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> !irq_n_o);

    // R4 / R5: an uncontested clear releases the line
    p_clear_releases_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> irq_n_o);

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] l_addr,
    input  logic          l_cs,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic          l_busy,
    input  logic [AW-1:0] r_addr,
    input  logic          r_cs,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic          r_busy,
    output logic          l_irq_n,
    output logic          r_irq_n
);
    localparam logic [AW-1:0] BOX_L = AW'(mbox_word(SIDE_L, AW));
    localparam logic [AW-1:0] BOX_R = AW'(mbox_word(SIDE_R, AW));

    logic [AW-1:0] addr_a [NUM_SIDES];
    mbx_ctrl_t     ctrl_a [NUM_SIDES];
    mbx_evt_t      evt_a  [NUM_SIDES];
    logic          irq_a  [NUM_SIDES];

    always_comb begin
        addr_a[SIDE_L] = l_addr;
        addr_a[SIDE_R] = r_addr;
        ctrl_a[SIDE_L] = '{cs: l_cs, wr: l_wr, oe: l_oe, busy: l_busy};
        ctrl_a[SIDE_R] = '{cs: r_cs, wr: r_wr, oe: r_oe, busy: r_busy};
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam mbx_side_e     ME   = mbx_side_e'(s);
        localparam mbx_side_e     PEER = peer_of(ME);
        localparam logic [AW-1:0] OWN  = (ME == SIDE_L) ? BOX_L : BOX_R;
        localparam logic [AW-1:0] OTH  = (ME == SIDE_L) ? BOX_R : BOX_L;

        mbx_port_decode #(
            .AW       (AW),
            .OWN_BOX  (OWN),
            .PEER_BOX (OTH)
        ) i_dec (
            .addr_i (addr_a[s]),
            .ctrl_i (ctrl_a[s]),
            .evt_o  (evt_a[s])
        );

        mbx_flag i_flag (
            .clk     (clk),
            .rst     (rst),
            .set_i   (evt_a[PEER].ring_peer),
            .clr_i   (evt_a[s].ack_own),
            .irq_n_o (irq_a[s])
        );
    end

    assign l_irq_n = irq_a[SIDE_L];
    assign r_irq_n = irq_a[SIDE_R];

    // R2: left write to the top word rings the right port
    p_ring_right_r2: assert property (@(posedge clk) disable iff (rst)
        (l_cs && l_wr && !l_busy && l_addr == BOX_R) |=> !r_irq_n);

    // R3: right write to the word below the top rings the left port
    p_ring_left_r3: assert property (@(posedge clk) disable iff (rst)
        (r_cs && r_wr && !r_busy && r_addr == BOX_L) |=> !l_irq_n);

    // R4: right owner acknowledge with no competing ring
    p_ack_right_r4: assert property (@(posedge clk) disable iff (rst)
        (r_cs && !r_wr && r_oe && !r_busy && r_addr == BOX_R &&
         !(l_cs && l_wr && !l_busy && l_addr == BOX_R)) |=> r_irq_n);

    // R7: an idle line only drops through an unblocked peer write
    p_no_ring_r7: assert property (@(posedge clk) disable iff (rst)
        (r_irq_n && !(l_cs && l_wr && !l_busy && l_addr == BOX_R)) |=> r_irq_n);

    // R8: a pending line only rises through an unblocked owner read
    p_no_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (!l_irq_n && !(l_cs && !l_wr && l_oe && !l_busy && l_addr == BOX_L)) |=> !l_irq_n);

endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] TOP1 = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_cs = 0, l_wr = 0, l_oe = 0, l_busy = 0;
    logic r_cs = 0, r_wr = 0, r_oe = 0, r_busy = 0;
    logic l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_l = 1'b1;
    bit exp_r = 1'b1;

    mbx_irq_ctrl #(.AW(AW)) i_mbx_irq_ctrl (
        .clk(clk), .rst(rst),
        .l_addr(l_addr), .l_cs(l_cs), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy),
        .r_addr(r_addr), .r_cs(r_cs), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    function automatic bit next_flag(bit cur, bit set, bit clr);
        if (set) return 1'b0;
        if (clr) return 1'b1;
        return cur;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive_l(logic [AW-1:0] a, bit cs, bit wr, bit oe, bit busy);
        l_addr = a; l_cs = cs; l_wr = wr; l_oe = oe; l_busy = busy;
    endtask

    task automatic drive_r(logic [AW-1:0] a, bit cs, bit wr, bit oe, bit busy);
        r_addr = a; r_cs = cs; r_wr = wr; r_oe = oe; r_busy = busy;
    endtask

    task automatic idle();
        drive_l('0, 0, 0, 0, 0);
        drive_r('0, 0, 0, 0, 0);
    endtask

    // One clock with the currently driven inputs, then compare both lines.
    task automatic step(string tag);
        bit set_r, clr_r, set_l, clr_l;
        set_r = l_cs && l_wr && !l_busy && (l_addr == TOP);
        clr_r = r_cs && !r_wr && r_oe && !r_busy && (r_addr == TOP);
        set_l = r_cs && r_wr && !r_busy && (r_addr == TOP1);
        clr_l = l_cs && !l_wr && l_oe && !l_busy && (l_addr == TOP1);
        @(posedge clk);
        @(negedge clk);
        exp_r = next_flag(exp_r, set_r, clr_r);
        exp_l = next_flag(exp_l, set_l, clr_l);
        check({tag, " right"}, r_irq_n, exp_r);
        check({tag, " left"},  l_irq_n, exp_l);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_l = 1'b1;
        exp_r = 1'b1;
        check("R1 reset right", r_irq_n, 1'b1);
        check("R1 reset left",  l_irq_n, 1'b1);
        rst = 1'b0;
    endtask

    function automatic logic [AW-1:0] pick_addr(int unsigned r);
        case (r % 4)
            0: return TOP;
            1: return TOP1;
            2: return TOP - 2;
            default: return AW'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        drive_l(TOP, 1, 1, 0, 0);         step("R2 left rings right");
        idle(); drive_l(TOP, 1, 0, 1, 0); step("R6 left reads right box");
        idle(); drive_r(TOP, 1, 0, 0, 0); step("R10 read without oe");
        idle(); drive_r(TOP, 0, 0, 1, 0); step("R10 read without cs");
        idle(); drive_r(TOP, 1, 0, 1, 1); step("R8 busy right read");
        idle();                           step("R11 hold low");
        idle(); drive_r(TOP, 1, 0, 1, 0); step("R4 right ack");
        idle(); drive_r(TOP1, 1, 1, 0, 0);step("R3 right rings left");
        idle(); drive_r(TOP1, 1, 0, 1, 0);step("R6 right reads left box");
        idle(); drive_l(TOP1, 1, 0, 1, 1);step("R8 busy left read");
        idle(); drive_l(TOP1, 1, 0, 1, 0);step("R5 left ack");
        idle(); drive_l(TOP, 1, 1, 0, 1); step("R7 busy left write");
        idle(); drive_r(TOP1, 1, 1, 0, 1);step("R7 busy right write");
        idle(); drive_l(TOP, 0, 1, 0, 0); step("R10 write without cs");
        idle(); drive_l(TOP1, 1, 1, 0, 0);step("R10 write own box");
        idle(); drive_l(TOP - 2, 1, 1, 0, 0); step("R10 write other word");
        idle(); drive_l(TOP, 1, 1, 0, 0); drive_r(TOP, 1, 0, 1, 0);
        step("R9 set with clear from high");
        drive_l(TOP, 1, 1, 0, 0); drive_r(TOP, 1, 0, 1, 0);
        step("R9 set with clear from low");
        idle(); drive_r(TOP1, 1, 1, 0, 0); drive_l(TOP1, 1, 0, 1, 0);
        step("R9 left set with clear");
        idle(); repeat (3) step("R11 idle hold");

        for (int i = 0; i < 3000; i++) begin
            drive_l(pick_addr($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), ($urandom % 4) == 0);
            drive_r(pick_addr($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), ($urandom % 4) == 0);
            step("R11 random model");
            if (i == 1500) do_reset();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule